// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits in the first stage of an instruction pipeline and turns 16-bit compressed instructions into their 32-bit base-ISA equivalents. A 32-bit fetch word may carry two compressed halfwords. A half-select input picks one of them, and the block returns the expanded instruction within the same cycle. The logic is purely combinational and adds no pipeline stage.

The supported compressed subset is register add, shift-left-immediate, word load and register jump. In the two-operand forms, the destination field is also used as the first source. A fetch word that starts with a full-length instruction in its lower half is passed through unchanged. Every other compressed encoding raises the illegal flag. Alignment of instructions across fetch words is handled elsewhere.

Top module: `cx_expander`

## Requirements
- R1: When `hi_sel` is 0 and `fetch_word[1:0]` is 2'b11, `insn_out` equals `fetch_word`, with `is_comp` = 0 and `illegal` = 0.
- R2: A halfword with bits [15:12] = 4'b1001, [1:0] = 2'b10, destination field [11:7] ≠ 0 and source field [6:2] ≠ 0 expands to the register add `{7'b0, src, dst, 3'b000, dst, 7'b0110011}`.
- R3: A halfword with [15:13] = 3'b000, [1:0] = 2'b10, bit 12 = 0 and [11:7] ≠ 0 expands to the shift-left-immediate `{7'b0, hw[6:2], dst, 3'b001, dst, 7'b0010011}`.
- R4: A halfword with [15:13] = 3'b010 and [1:0] = 2'b00 expands to a word load. The destination is x(8+hw[4:2]) and the base is x(8+hw[9:7]). The offset is zero-extended and equals {hw[5], hw[12:10], hw[6], 2'b00}. The load has funct3 = 3'b010 and opcode 7'b0000011.
- R5: A halfword with [15:12] = 4'b1000, [6:2] = 0, [1:0] = 2'b10 and [11:7] ≠ 0 expands to a register jump with zero offset and destination x0: `{12'b0, rs1, 3'b000, 5'b0, 7'b1100111}`.
- R6: `hi_sel` = 0 expands `fetch_word[15:0]` and `hi_sel` = 1 expands `fetch_word[31:16]`. The unselected half has no effect on the outputs.
- R7: Any selected compressed halfword (low bits other than 2'b11) that matches none of R2–R5 gives `illegal` = 1, `is_comp` = 1 and `insn_out` = 0. This covers register fields that are zero where R2, R3 or R5 forbid it, bit 12 set in the shift, the move form, the breakpoint form and the all-zero halfword.
- R8: When `hi_sel` is 1 and `fetch_word[17:16]` is 2'b11, the outputs are `illegal` = 1, `is_comp` = 0 and `insn_out` = 0.
- R9: When a legal compressed halfword is selected, the outputs are `is_comp` = 1 and `illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_word | input | 32 | Fetched word holding one full instruction or two halfwords |
| hi_sel | input | 1 | 0 selects the lower halfword, 1 selects the upper halfword |
| insn_out | output | 32 | Expanded or passed-through instruction; zero when illegal |
| is_comp | output | 1 | Selected halfword is a compressed instruction |
| illegal | output | 1 | Selected encoding is not supported |

## Verification
Two lane expansions can share one fetch word. Two different compressed instructions are packed into a single word, and that word is held constant while `hi_sel` toggles. Each half must then expand to its own hand-encoded equivalent, with no influence from its neighbour. A further case puts a full-length opcode pattern next to a legal compressed halfword. This checks that the straddle flag from R8 and the lower-half expansion stay separate.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int INSN_W = 32;
  localparam int HALF_W = 16;
  localparam int LANES  = INSN_W / HALF_W;
  localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int REG_W  = 5;
  localparam int CREG_W = 3;

  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_LOAD = 7'b0000011;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_LW   = 3'b010;
  localparam logic [2:0] F3_JALR = 3'b000;

  function automatic logic [INSN_W-1:0] enc_r(
    input logic [6:0] f7, input logic [REG_W-1:0] rs2,
    input logic [REG_W-1:0] rs1, input logic [2:0] f3,
    input logic [REG_W-1:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [INSN_W-1:0] enc_i(
    input logic [11:0] imm, input logic [REG_W-1:0] rs1,
    input logic [2:0] f3, input logic [REG_W-1:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [REG_W-1:0] creg(input logic [CREG_W-1:0] r);
    return {2'b01, r};
  endfunction
endpackage

// File: rtl/cx_rvc_lane.sv
module cx_rvc_lane
  import cx_pkg::*;
(
  input  logic [HALF_W-1:0] hw,
  output logic [INSN_W-1:0] expd,
  output logic              legal,
  output logic              full_start
);
  logic [1:0]       quad;
  logic [2:0]       f3;
  logic [REG_W-1:0] dst;
  logic [REG_W-1:0] src;
  logic [11:0]      lw_off;

  assign quad   = hw[1:0];
  assign f3     = hw[15:13];
  assign dst    = hw[11:7];
  assign src    = hw[6:2];
  assign lw_off = {5'b0, hw[5], hw[12:10], hw[6], 2'b00};

  always_comb begin
    expd       = '0;
    legal      = 1'b0;
    full_start = 1'b0;
    unique case (quad)
      2'b11: full_start = 1'b1;
      2'b00: begin
        if (f3 == 3'b010) begin
          legal = 1'b1;
          expd  = enc_i(lw_off, creg(hw[9:7]), F3_LW, creg(hw[4:2]), OP_LOAD);
        end
      end
      2'b10: begin
        if (f3 == 3'b000) begin
          if (!hw[12] && dst != '0) begin
            legal = 1'b1;
            expd  = enc_i({7'b0, src}, dst, F3_SLL, dst, OP_IMM);
          end
        end else if (f3 == 3'b100) begin
          if (!hw[12]) begin
            if (src == '0 && dst != '0) begin
              legal = 1'b1;
              expd  = enc_i(12'b0, dst, F3_JALR, '0, OP_JALR);
            end
          end else if (dst != '0 && src != '0) begin
            legal = 1'b1;
            expd  = enc_r(7'b0, src, dst, F3_ADD, dst, OP_REG);
          end
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    if (legal && expd[6:0] == OP_REG)
      a_r2_dest_reused: assert (expd[11:7] == hw[11:7] && expd[19:15] == hw[11:7]
                                && expd[24:20] == hw[6:2]);
    if (legal && expd[6:0] == OP_IMM)
      a_r3_shift_amount: assert (expd[24:20] == hw[6:2] && expd[31:25] == 7'b0
                                 && expd[19:15] == expd[11:7]);
    if (legal && expd[6:0] == OP_LOAD)
      a_r4_load_window: assert (expd[19:18] == 2'b01 && expd[11:10] == 2'b01
                                && expd[21:20] == 2'b00 && expd[31:27] == 5'b0);
    if (legal && expd[6:0] == OP_JALR)
      a_r5_link_dropped: assert (expd[11:7] == 5'b0 && expd[31:20] == 12'b0
                                 && expd[19:15] != 5'b0);
    if (full_start)
      a_r7_full_not_legal: assert (!legal);
  end
endmodule

// File: rtl/cx_lane_pick.sv
module cx_lane_pick
  import cx_pkg::*;
(
  input  logic [LANES-1:0][INSN_W-1:0] expd,
  input  logic [LANES-1:0]             legal,
  input  logic [LANES-1:0]             full_start,
  input  logic [SEL_W-1:0]             sel,
  input  logic [INSN_W-1:0]            fetch_word,
  output logic [INSN_W-1:0]            insn_out,
  output logic                         is_comp,
  output logic                         illegal
);
  always_comb begin
    insn_out = '0;
    is_comp  = 1'b0;
    illegal  = 1'b0;
    if (full_start[sel]) begin
      if (sel == '0) insn_out = fetch_word;
      else           illegal  = 1'b1;
    end else begin
      is_comp = 1'b1;
      if (legal[sel]) insn_out = expd[sel];
      else            illegal  = 1'b1;
    end
  end
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
(
  input  logic [31:0] fetch_word,
  input  logic        hi_sel,
  output logic [31:0] insn_out,
  output logic        is_comp,
  output logic        illegal
);
  logic [LANES-1:0][INSN_W-1:0] lane_expd;
  logic [LANES-1:0]             lane_legal;
  logic [LANES-1:0]             lane_full;
  logic [SEL_W-1:0]             sel;

  assign sel = SEL_W'(hi_sel);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cx_rvc_lane u_lane (
      .hw         (fetch_word[g*HALF_W +: HALF_W]),
      .expd       (lane_expd[g]),
      .legal      (lane_legal[g]),
      .full_start (lane_full[g])
    );
  end

  cx_lane_pick u_pick (
    .expd       (lane_expd),
    .legal      (lane_legal),
    .full_start (lane_full),
    .sel        (sel),
    .fetch_word (fetch_word),
    .insn_out   (insn_out),
    .is_comp    (is_comp),
    .illegal    (illegal)
  );

  always_comb begin
    if (!hi_sel && fetch_word[1:0] == 2'b11)
      a_r1_full_passthrough: assert (insn_out == fetch_word && !is_comp && !illegal);
    if (hi_sel && fetch_word[17:16] == 2'b11)
      a_r8_straddle_flagged: assert (illegal && !is_comp && insn_out == '0);
    if (illegal)
      a_r7_illegal_zeroed: assert (insn_out == '0);
    if (is_comp && !illegal)
      a_r9_comp_valid: assert (insn_out[1:0] == 2'b11);
  end
endmodule

// File: tb/cx_expander_tb.sv
module cx_expander_tb;
  typedef struct {
    logic [31:0] word;
    logic        hsel;
    logic [31:0] insn;
    logic        comp;
    logic        ill;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_word = '0;
  logic        hi_sel = 1'b0;
  logic [31:0] insn_out;
  logic        is_comp;
  logic        illegal;
  item_t       sb_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cx_expander u_dut (
    .fetch_word (fetch_word),
    .hi_sel     (hi_sel),
    .insn_out   (insn_out),
    .is_comp    (is_comp),
    .illegal    (illegal)
  );

  task automatic drive(input logic [31:0] w, input logic h, input logic [31:0] ei,
                       input logic ec, input logic el, input string tag);
    item_t it;
    @(negedge clk);
    fetch_word = w;
    hi_sel     = h;
    it.word = w; it.hsel = h; it.insn = ei; it.comp = ec; it.ill = el; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic comp16(input logic [15:0] lo, input logic [31:0] ei, input string tag);
    drive({16'hFFFF, lo}, 1'b0, ei, 1'b1, 1'b0, tag);
  endtask

  task automatic bad16(input logic [15:0] lo, input string tag);
    drive({16'h0000, lo}, 1'b0, 32'h0, 1'b1, 1'b1, tag);
  endtask

  always @(posedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (insn_out !== it.insn || is_comp !== it.comp || illegal !== it.ill) begin
        n_bad++;
        $display("FAIL %s word=%h sel=%0d got insn=%h comp=%0b ill=%0b exp insn=%h comp=%0b ill=%0b",
                 it.tag, it.word, it.hsel, insn_out, is_comp, illegal, it.insn, it.comp, it.ill);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    drive(32'h0, 1'b0, 32'h0, 1'b1, 1'b1, "R7 reset-state all-zero");
    comp16(16'h952E, 32'h00B50533, "R2 add x10,x11");
    comp16(16'h9FFE, 32'h01FF8FB3, "R2 add x31,x31");
    comp16(16'h058A, 32'h00259593, "R3 slli x11,2");
    comp16(16'h0FFE, 32'h01FF9F93, "R3 slli x31,31");
    comp16(16'h4108, 32'h00052503, "R4 lw off0");
    comp16(16'h5FE4, 32'h07C7A483, "R4 lw off124");
    comp16(16'h4020, 32'h04042403, "R4 lw off64");
    comp16(16'h4040, 32'h00442403, "R4 lw off4");
    comp16(16'h8082, 32'h00008067, "R5 jr x1");
    comp16(16'h8F82, 32'h000F8067, "R5 jr x31");
    drive(32'h00B50533, 1'b0, 32'h00B50533, 1'b0, 1'b0, "R1 passthrough");
    drive(32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, "R1 passthrough ones");
    drive(32'h4108952E, 1'b0, 32'h00B50533, 1'b1, 1'b0, "R6 packed lower");
    drive(32'h4108952E, 1'b1, 32'h00052503, 1'b1, 1'b0, "R6 packed upper");
    drive(32'h8082058A, 1'b1, 32'h00008067, 1'b1, 1'b0, "R6 upper jr");
    drive(32'h8082058A, 1'b0, 32'h00259593, 1'b1, 1'b0, "R6 lower slli");
    drive(32'h0003952E, 1'b1, 32'h0, 1'b0, 1'b1, "R8 upper full start");
    drive(32'h0003952E, 1'b0, 32'h00B50533, 1'b1, 1'b0, "R9 lower beside straddle");
    bad16(16'h158A, "R7 slli bit12");
    bad16(16'h000A, "R7 slli rd0");
    bad16(16'h8002, "R7 jr rs1 0");
    bad16(16'h9002, "R7 breakpoint form");
    bad16(16'h852E, "R7 move form");
    bad16(16'h902E, "R7 add rd0");
    bad16(16'h0505, "R7 other quadrant");
    drive(32'h952E_0000, 1'b1, 32'h00B50533, 1'b1, 1'b0, "R9 upper add flags");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule